// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block buffers 24-bit PCM samples for one direction of an audio serial port. On one side sits a small register port used by a processor: a data register, a status register and a control register. On the other side sits the serializer, modelled as a single strobe that either removes one sample (transmit build) or delivers one sample (receive build). A parameter picks the direction. In the transmit build the processor writes samples and the serializer pops them. In the receive build the serializer pushes samples and the processor reads them.

The backing RAM holds 256 words shifted left by a 3-bit size parameter. Capacity is counted in whole frames. Each frame uses RAM for the channel count rounded up to a power of two. With 256 words that gives 256 frames for one channel, 128 for two, 64 for three or four, and 32 for five to eight. The usable sample capacity is the frame capacity times the real channel count. The channel count comes from an input pin but is only taken when the FIFO is cleared. A half-full interrupt output, level-sensitive and gated by an enable bit, tells software when to refill or drain the FIFO.

Top module: `chan_sample_fifo`

## Requirements
- R1: After reset the FIFO is empty. Status and control read 0, `irq` is 0, and the channel count is 2, so the capacity is 128 frames (256 samples) until the first clear.
- R2: With channel count c and RAM of W = 256<<SIZE_CODE words, the frame capacity is W divided by c rounded up to a power of two, and the sample capacity is that times c. Samples offered beyond the sample capacity are not stored.
- R3: Status bits [16:8] give the stored sample count divided by the channel count, rounded down.
- R4: Status bit 4 is a sticky overrun flag. It is set by a write-side attempt while the FIFO is full, and that attempt changes neither the stored data nor the count.
- R5: Status bit 0 is a sticky underrun flag. It is set by a read-side attempt while the FIFO is empty. That attempt returns zero and leaves the pointers unchanged.
- R6: A write to status clears each of the two flags whose bit is written 0 and keeps a flag whose bit is written 1. Writing zero clears both.
- R7: Writing control with bit 0 set empties the FIFO and resets both pointers. The flags keep their value.
- R8: The `cfg_chans` pin is sampled only at a clear; a change without a clear has no effect. A value of 0 acts as 1 and values above 8 act as 8.
- R9: Control bit 20 is the half-full interrupt enable. It reads back at bit 20. While it is 0, `irq` stays 0.
- R10: When enabled, transmit `irq` is high while 2×stored samples ≤ sample capacity. Receive `irq` is high while 2×stored samples ≥ sample capacity.
- R11: Data bits [23:0] are stored and bits [31:24] are ignored. Reads return zero in [31:24]. Samples leave in the order they entered, across pointer wrap.
- R12: Register offsets on `bus_addr` are 0 for control, 1 for status, 2 for data. Offset 3 reads 0 and ignores writes. A read returns its value on `bus_rdata` one clock after the `bus_rd` edge. A data read in the transmit build returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_chans | input | 4 | Channel count taken at a clear |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| ser_strobe | input | 1 | Serializer pop (transmit) or push (receive) |
| ser_din | input | DATA_W | Sample from serializer (receive build) |
| ser_dout | output | DATA_W | Sample to serializer (transmit build), valid the clock after a pop |
| irq | output | 1 | Half-full interrupt request, level |

## Verification
The hardest conditions to reach are the exact half-capacity and full boundaries when the sample capacity is not a power of two (3, 5, 6 and 7 channels). Here the pointers wrap at odd limits and the frame count needs a true division. The stimulus sweeps every channel count from 1 to 8. For each count it fills past capacity and checks `irq` after every single write. It then drains while comparing against a queue, and finally mixes random writes and pops at six channels so the pointers wrap many times. Directed sequences also change `cfg_chans` without a clear and use out-of-range counts, to confirm that only a clear takes them.

// File: rtl/csf_pkg.sv
package csf_pkg;

   localparam int BUS_W         = 32;
   localparam int STAT_CNT_W    = 9;
   localparam int STAT_CNT_LSB  = 8;
   localparam int STAT_OVR_BIT  = 4;
   localparam int STAT_UDR_BIT  = 0;
   localparam int CTRL_CLR_BIT  = 0;
   localparam int CTRL_HALF_BIT = 20;
   localparam int MAX_CHANS     = 8;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // log2 of the channel count rounded up to a power of two
   function automatic logic [1:0] chan_group_log2(input logic [3:0] ch);
      logic [1:0] r;
      if (ch <= 4'd1)      r = 2'd0;
      else if (ch == 4'd2) r = 2'd1;
      else if (ch <= 4'd4) r = 2'd2;
      else                 r = 2'd3;
      return r;
   endfunction

   function automatic logic [3:0] chan_clamp(input logic [3:0] ch);
      logic [3:0] r;
      if (ch == 4'd0)                  r = 4'd1;
      else if (ch > 4'(MAX_CHANS))     r = 4'(MAX_CHANS);
      else                             r = ch;
      return r;
   endfunction

endpackage

// File: rtl/csf_geometry.sv
module csf_geometry
   import csf_pkg::*;
#(
   parameter int RAM_WORDS = 256,
   parameter int CW        = 9
)(
   input  logic [3:0]            chans,
   input  logic [CW-1:0]         samples,
   output logic [CW-1:0]         cap_samples,
   output logic [STAT_CNT_W-1:0] frames
);
   localparam logic [CW-1:0] WORDS_C = CW'(RAM_WORDS);
   localparam logic [CW-1:0] SAT_C   = CW'((1 << STAT_CNT_W) - 1);

   logic [CW-1:0] frame_cap;
   logic [CW-1:0] frames_full;

   always_comb begin
      frame_cap   = WORDS_C >> chan_group_log2(chans);
      cap_samples = CW'(frame_cap * CW'(chans));
   end

   // one constant divider per legal channel count
   always_comb begin
      frames_full = '0;
      for (int c = 1; c <= MAX_CHANS; c++) begin
         if (chans == 4'(c)) frames_full = samples / CW'(c);
      end
   end

   generate
      if (CW > STAT_CNT_W) begin : g_sat
         assign frames = (frames_full > SAT_C) ? {STAT_CNT_W{1'b1}}
                                               : frames_full[STAT_CNT_W-1:0];
      end else begin : g_nosat
         assign frames = STAT_CNT_W'(frames_full);
      end
   endgenerate

endmodule

// File: rtl/csf_store.sv
module csf_store #(
   parameter int DATA_W    = 24,
   parameter int RAM_WORDS = 256,
   parameter int AW        = 8,
   parameter int CW        = 9
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   input  logic [CW-1:0]     cap_samples,
   output logic [DATA_W-1:0] head,
   output logic [CW-1:0]     cnt,
   output logic              full,
   output logic              empty,
   output logic              push_ok,
   output logic              pop_ok
);
   logic [DATA_W-1:0] mem [RAM_WORDS];
   logic [AW-1:0]     wp, rp;
   logic [AW-1:0]     wp_nx, rp_nx;

   assign full    = (cnt >= cap_samples);
   assign empty   = (cnt == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;
   assign head    = mem[rp];

   // pointers wrap at the sample capacity, which need not be a power of two
   always_comb begin
      wp_nx = (({1'b0, wp} + CW'(1)) == cap_samples) ? '0 : wp + AW'(1);
      rp_nx = (({1'b0, rp} + CW'(1)) == cap_samples) ? '0 : rp + AW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push_ok) wp <= wp_nx;
         if (pop_ok)  rp <= rp_nx;
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wp] <= push_data;
   end

endmodule

// File: rtl/chan_sample_fifo.sv
module chan_sample_fifo
   import csf_pkg::*;
#(
   parameter int SIZE_CODE   = 0,
   parameter int DATA_W      = 24,
   parameter bit IS_TX       = 1'b1,
   parameter int RESET_CHANS = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        cfg_chans,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [1:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ser_strobe,
   input  logic [DATA_W-1:0] ser_din,
   output logic [DATA_W-1:0] ser_dout,
   output logic              irq
);
   localparam int RAM_WORDS = 256 << SIZE_CODE;
   localparam int AW        = $clog2(RAM_WORDS);
   localparam int CW        = AW + 1;

   generate
      if (SIZE_CODE < 0 || SIZE_CODE > 7) begin : g_bad_size
         $error("SIZE_CODE must be 0..7");
      end
      if (DATA_W < 16 || DATA_W > 24) begin : g_bad_width
         $error("DATA_W must be 16..24");
      end
      if (RESET_CHANS < 1 || RESET_CHANS > MAX_CHANS) begin : g_bad_chans
         $error("RESET_CHANS must be 1..8");
      end
   endgenerate

   // bus decode
   reg_sel_e sel;
   logic wr_ctrl, wr_stat, wr_dat, rd_dat, clr_pulse;
   assign sel       = reg_sel_e'(bus_addr);
   assign wr_ctrl   = bus_wr && (sel == REG_CTRL);
   assign wr_stat   = bus_wr && (sel == REG_STAT);
   assign wr_dat    = bus_wr && (sel == REG_DATA);
   assign rd_dat    = bus_rd && (sel == REG_DATA);
   assign clr_pulse = wr_ctrl && bus_wdata[CTRL_CLR_BIT];

   logic unused_in;
   assign unused_in = ^{bus_wdata, ser_din};

   // configuration state
   logic [3:0] chans_q;
   logic       irq_en_q;
   logic       ovr_q, udr_q;

   // datapath wiring
   logic              push_req, pop_req;
   logic [DATA_W-1:0] push_val;
   logic [DATA_W-1:0] head;
   logic [CW-1:0]     cnt, cap_samples;
   logic              full, empty, push_ok, pop_ok;
   logic [STAT_CNT_W-1:0] frames;
   logic [DATA_W-1:0] cpu_pop_word;
   logic              half_cond;
   logic [CW:0]       cnt_x2, cap_x1;

   assign cnt_x2 = {cnt, 1'b0};
   assign cap_x1 = {1'b0, cap_samples};

   generate
      if (IS_TX) begin : g_tx
         logic [DATA_W-1:0] sdo_q;
         assign push_req     = wr_dat;
         assign push_val     = bus_wdata[DATA_W-1:0];
         assign pop_req      = ser_strobe;
         assign cpu_pop_word = '0;
         assign half_cond    = (cnt_x2 <= cap_x1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sdo_q <= '0;
            else if (pop_req) sdo_q <= pop_ok ? head : '0;
         end
         assign ser_dout = sdo_q;
      end else begin : g_rx
         assign push_req     = ser_strobe;
         assign push_val     = ser_din;
         assign pop_req      = rd_dat;
         assign cpu_pop_word = pop_ok ? head : '0;
         assign half_cond    = (cnt_x2 >= cap_x1);
         assign ser_dout     = '0;
      end
   endgenerate

   csf_geometry #(
      .RAM_WORDS (RAM_WORDS),
      .CW        (CW)
   ) u_geom (
      .chans       (chans_q),
      .samples     (cnt),
      .cap_samples (cap_samples),
      .frames      (frames)
   );

   csf_store #(
      .DATA_W    (DATA_W),
      .RAM_WORDS (RAM_WORDS),
      .AW        (AW),
      .CW        (CW)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (clr_pulse),
      .push        (push_req & ~clr_pulse),
      .push_data   (push_val),
      .pop         (pop_req & ~clr_pulse),
      .cap_samples (cap_samples),
      .head        (head),
      .cnt         (cnt),
      .full        (full),
      .empty       (empty),
      .push_ok     (push_ok),
      .pop_ok      (pop_ok)
   );

   // control and sticky flags
   logic ovr_set, udr_set;
   assign ovr_set = push_req & full  & ~clr_pulse;
   assign udr_set = pop_req  & empty & ~clr_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chans_q  <= 4'(RESET_CHANS);
         irq_en_q <= 1'b0;
         ovr_q    <= 1'b0;
         udr_q    <= 1'b0;
      end else begin
         if (wr_ctrl)   irq_en_q <= bus_wdata[CTRL_HALF_BIT];
         if (clr_pulse) chans_q  <= chan_clamp(cfg_chans);
         ovr_q <= (ovr_q & ~(wr_stat & ~bus_wdata[STAT_OVR_BIT])) | ovr_set;
         udr_q <= (udr_q & ~(wr_stat & ~bus_wdata[STAT_UDR_BIT])) | udr_set;
      end
   end

   // registered read data
   logic [31:0] rd_word;
   always_comb begin
      rd_word = '0;
      unique case (sel)
         REG_CTRL: rd_word[CTRL_HALF_BIT] = irq_en_q;
         REG_STAT: begin
            rd_word[STAT_CNT_LSB +: STAT_CNT_W] = frames;
            rd_word[STAT_OVR_BIT]               = ovr_q;
            rd_word[STAT_UDR_BIT]               = udr_q;
         end
         REG_DATA: rd_word[DATA_W-1:0] = cpu_pop_word;
         default:  rd_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_word;
   end

   assign irq = irq_en_q & half_cond;

endmodule

// File: rtl/csf_chk.sv
module csf_chk #(
   parameter int CW     = 9,
   parameter int DATA_W = 24,
   parameter bit IS_TX  = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              clr,
   input logic              push_req,
   input logic              pop_req,
   input logic              full,
   input logic              empty,
   input logic [CW-1:0]     cnt,
   input logic [CW-1:0]     cap,
   input logic              ovr,
   input logic              udr,
   input logic              irq_en,
   input logic              irq,
   input logic [3:0]        chans,
   input logic              ser_strobe,
   input logic [DATA_W-1:0] ser_dout
);

   assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= cap);

   assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !clr) |=> ovr);

   assert_overrun_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_req && full && !clr && !pop_req) |=> (cnt == $past(cnt)));

   assert_underrun_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !clr) |=> udr);

   assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   assert_chans_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> $stable(chans));

   assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   generate
      if (IS_TX) begin : g_tx_chk
         assert_empty_pop_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ser_strobe && empty && !clr) |=> (ser_dout == '0));
      end
   endgenerate

endmodule

bind chan_sample_fifo csf_chk #(
   .CW     (CW),
   .DATA_W (DATA_W),
   .IS_TX  (IS_TX)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clr        (clr_pulse),
   .push_req   (push_req),
   .pop_req    (pop_req),
   .full       (full),
   .empty      (empty),
   .cnt        (cnt),
   .cap        (cap_samples),
   .ovr        (ovr_q),
   .udr        (udr_q),
   .irq_en     (irq_en_q),
   .irq        (irq),
   .chans      (chans_q),
   .ser_strobe (ser_strobe),
   .ser_dout   (ser_dout)
);

// File: tb/chan_sample_fifo_tb.sv
module chan_sample_fifo_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_NONE = 2'd3;
   localparam logic [31:0] C_CLR = 32'h0000_0001, C_EN = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_chans = 4'd2;

   logic        t_wr = 0, t_rd = 0, t_strobe = 0, t_irq;
   logic [1:0]  t_addr = 0;
   logic [31:0] t_wdata = 0, t_rdata;
   logic [23:0] t_din = 0, t_dout;

   logic        r_wr = 0, r_rd = 0, r_strobe = 0, r_irq;
   logic [1:0]  r_addr = 0;
   logic [31:0] r_wdata = 0, r_rdata;
   logic [23:0] r_din = 0, r_dout;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   chan_sample_fifo #(.IS_TX(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans),
      .bus_wr(t_wr), .bus_rd(t_rd), .bus_addr(t_addr), .bus_wdata(t_wdata),
      .bus_rdata(t_rdata), .ser_strobe(t_strobe), .ser_din(t_din),
      .ser_dout(t_dout), .irq(t_irq));

   chan_sample_fifo #(.IS_TX(1'b0)) u_rx (
      .clk(clk), .rst_n(rst_n), .cfg_chans(cfg_chans),
      .bus_wr(r_wr), .bus_rd(r_rd), .bus_addr(r_addr), .bus_wdata(r_wdata),
      .bus_rdata(r_rdata), .ser_strobe(r_strobe), .ser_din(r_din),
      .ser_dout(r_dout), .irq(r_irq));

   // expected geometry, from the requirements
   function automatic int fcap(input int ch);
      int lg;
      lg = (ch <= 1) ? 0 : (ch == 2) ? 1 : (ch <= 4) ? 2 : 3;
      return 256 >> lg;
   endfunction

   function automatic int scap(input int ch);
      return fcap(ch) * ch;
   endfunction

   function automatic logic [31:0] stat_exp(input int fr, input bit o, input bit u);
      logic [31:0] s;
      s = '0;
      s[16:8] = fr[8:0];
      s[4] = o;
      s[0] = u;
      return s;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input bit rx, input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      if (rx) begin r_wr = 1; r_addr = a; r_wdata = d; end
      else    begin t_wr = 1; t_addr = a; t_wdata = d; end
      @(negedge clk);
      t_wr = 0; r_wr = 0;
   endtask

   task automatic bus_read(input bit rx, input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      if (rx) begin r_rd = 1; r_addr = a; end
      else    begin t_rd = 1; t_addr = a; end
      @(negedge clk);
      t_rd = 0; r_rd = 0;
      d = rx ? r_rdata : t_rdata;
   endtask

   task automatic ser_op(input bit rx, input logic [23:0] din, output logic [23:0] dout);
      @(negedge clk);
      if (rx) begin r_strobe = 1; r_din = din; end
      else    t_strobe = 1;
      @(negedge clk);
      t_strobe = 0; r_strobe = 0;
      dout = rx ? r_dout : t_dout;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] rd, w;
      logic [23:0] d, e;
      logic [23:0] q[$];
      int sc, nk;
      int rx_ch[3] = '{1, 3, 8};
      void'($urandom(32'd5813));

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(0, A_STAT, rd);  chk("R1 status after reset", rd, 32'h0);
      bus_read(0, A_CTRL, rd);  chk("R1 control after reset", rd, 32'h0);
      chk("R1 irq after reset", {31'b0, t_irq}, 32'h0);
      for (int k = 0; k < 257; k++) bus_write(0, A_DATA, k);
      bus_read(0, A_STAT, rd);
      chk("R1 R2 reset channel count two", rd, stat_exp(128, 1, 0));

      // transmit sweep over every channel count
      for (int ch = 1; ch <= 8; ch++) begin
         sc = scap(ch);
         cfg_chans = 4'(ch);
         bus_write(0, A_CTRL, C_EN | C_CLR);
         bus_write(0, A_STAT, 32'h0);
         bus_read(0, A_STAT, rd);
         chk("R7 R6 clear and flag clear", rd, 32'h0);
         chk("R10 tx irq when empty", {31'b0, t_irq}, 32'h1);
         q.delete();
         for (int k = 1; k <= sc + 2; k++) begin
            w = $urandom;
            bus_write(0, A_DATA, w);
            if (k <= sc) q.push_back(w[23:0]);
            nk = (k > sc) ? sc : k;
            chk("R10 tx irq level", {31'b0, t_irq}, {31'b0, (2 * nk <= sc)});
         end
         bus_read(0, A_STAT, rd);
         chk("R2 R3 R4 full status", rd, stat_exp(fcap(ch), 1, 0));
         for (int k = 0; k < sc; k++) begin
            ser_op(0, 24'h0, d);
            e = q.pop_front();
            chk("R11 tx order and width", {8'h0, d}, {8'h0, e});
         end
         ser_op(0, 24'h0, d);
         chk("R5 empty pop returns zero", {8'h0, d}, 32'h0);
         bus_read(0, A_STAT, rd);
         chk("R5 underrun flag", rd, stat_exp(0, 1, 1));
         if (ch == 8) begin
            bus_write(0, A_STAT, 32'h0000_0010);
            bus_read(0, A_STAT, rd);
            chk("R6 keep overrun clear underrun", rd, stat_exp(0, 1, 0));
            bus_write(0, A_STAT, 32'h0000_0001);
            bus_read(0, A_STAT, rd);
            chk("R6 clear overrun", rd, 32'h0);
         end
      end

      // R7 clear keeps flags
      cfg_chans = 4'd2;
      bus_write(0, A_CTRL, C_CLR);
      for (int k = 0; k < 260; k++) bus_write(0, A_DATA, k);
      bus_write(0, A_CTRL, C_CLR);
      bus_read(0, A_STAT, rd);
      chk("R7 clear keeps overrun flag", rd, stat_exp(0, 1, 0));
      bus_write(0, A_STAT, 32'h0);

      // R9 enable gating and readback
      chk("R9 irq off when disabled", {31'b0, t_irq}, 32'h0);
      bus_read(0, A_CTRL, rd);  chk("R9 control readback off", rd, 32'h0);
      bus_write(0, A_CTRL, C_EN);
      chk("R9 irq on when enabled", {31'b0, t_irq}, 32'h1);
      bus_read(0, A_CTRL, rd);  chk("R9 control readback on", rd, C_EN);

      // R8 channel count only taken at clear, with clamping
      cfg_chans = 4'd1;
      bus_write(0, A_CTRL, C_CLR);
      cfg_chans = 4'd8;
      for (int k = 0; k < 3; k++) bus_write(0, A_DATA, k);
      bus_read(0, A_STAT, rd);
      chk("R8 count uses latched one channel", rd, stat_exp(3, 0, 0));
      for (int k = 0; k < 297; k++) bus_write(0, A_DATA, k);
      bus_read(0, A_STAT, rd);
      chk("R8 capacity of latched one channel", rd, stat_exp(256, 1, 0));
      cfg_chans = 4'd12;
      bus_write(0, A_CTRL, C_CLR);
      bus_write(0, A_STAT, 32'h0);
      for (int k = 0; k < 260; k++) bus_write(0, A_DATA, k);
      bus_read(0, A_STAT, rd);
      chk("R8 out of range acts as eight", rd, stat_exp(32, 1, 0));
      cfg_chans = 4'd0;
      bus_write(0, A_CTRL, C_CLR);
      bus_write(0, A_STAT, 32'h0);
      for (int k = 0; k < 5; k++) bus_write(0, A_DATA, k);
      bus_read(0, A_STAT, rd);
      chk("R8 zero acts as one", rd, stat_exp(5, 0, 0));

      // R3 partial frames round down
      cfg_chans = 4'd3;
      bus_write(0, A_CTRL, C_CLR);
      for (int k = 0; k < 5; k++) bus_write(0, A_DATA, k);
      bus_read(0, A_STAT, rd);  chk("R3 five samples three channels", rd, stat_exp(1, 0, 0));
      bus_write(0, A_DATA, 32'h5);
      bus_read(0, A_STAT, rd);  chk("R3 six samples three channels", rd, stat_exp(2, 0, 0));

      // R12 unused offset and transmit data read
      bus_write(0, A_NONE, 32'hFFFF_FFFF);
      bus_read(0, A_STAT, rd);  chk("R12 offset three write ignored", rd, stat_exp(2, 0, 0));
      bus_read(0, A_NONE, rd);  chk("R12 offset three reads zero", rd, 32'h0);
      bus_read(0, A_DATA, rd);  chk("R12 tx data read zero", rd, 32'h0);
      bus_read(0, A_STAT, rd);  chk("R12 tx data read leaves fifo", rd, stat_exp(2, 0, 0));

      // receive build
      foreach (rx_ch[i]) begin
         sc = scap(rx_ch[i]);
         cfg_chans = 4'(rx_ch[i]);
         bus_write(1, A_CTRL, C_EN | C_CLR);
         bus_write(1, A_STAT, 32'h0);
         chk("R10 rx irq when empty", {31'b0, r_irq}, 32'h0);
         q.delete();
         for (int k = 1; k <= sc + 1; k++) begin
            e = 24'($urandom);
            ser_op(1, e, d);
            if (k <= sc) q.push_back(e);
            nk = (k > sc) ? sc : k;
            chk("R10 rx irq level", {31'b0, r_irq}, {31'b0, (2 * nk >= sc)});
         end
         bus_read(1, A_STAT, rd);
         chk("R2 R4 rx full status", rd, stat_exp(fcap(rx_ch[i]), 1, 0));
         for (int k = 0; k < sc; k++) begin
            bus_read(1, A_DATA, rd);
            e = q.pop_front();
            chk("R11 rx order and zero upper bits", rd, {8'h0, e});
         end
         bus_read(1, A_DATA, rd);
         chk("R5 rx empty read zero", rd, 32'h0);
         bus_read(1, A_STAT, rd);
         chk("R5 rx underrun flag", rd, stat_exp(0, 1, 1));
      end

      // random traffic at six channels on transmit
      cfg_chans = 4'd6;
      sc = scap(6);
      bus_write(0, A_CTRL, C_CLR);
      bus_write(0, A_STAT, 32'h0);
      q.delete();
      for (int it = 0; it < 1500; it++) begin
         if (($urandom % 100) < ((q.size() < 20) ? 80 : 45)) begin
            w = $urandom;
            bus_write(0, A_DATA, w);
            if (q.size() < sc) q.push_back(w[23:0]);
         end else begin
            ser_op(0, 24'h0, d);
            e = (q.size() > 0) ? q.pop_front() : 24'h0;
            chk("R11 random tx data", {8'h0, d}, {8'h0, e});
         end
         if (it % 100 == 99) begin
            bus_read(0, A_STAT, rd);
            chk("R3 random frame count", rd & 32'h0001_FF00, stat_exp(q.size() / 6, 0, 0));
         end
      end

      summary();
      $finish;
   end

endmodule